// File: doc/BRIEF.md
# SHA-1 Message Schedule Generator

This block produces the 32-bit schedule word W[t] for each of the 80 SHA-1 rounds. It keeps only a window of sixteen 32-bit registers and never holds all 80 expanded words. An `init_i` pulse loads the whole 512-bit block into the window in one clock. After that, the round engine pulses `next_i` once for each round it consumes. The word on `w_o` is combinational from the window and the round counter, so the engine can use it in the same cycle that it raises `next_i`.

The engine and the schedule advance in lockstep. The word stream has no valid/ready pair. The engine applies back-pressure by leaving `next_i` low: the word and the window then hold for as long as it waits. For rounds 16 to 79 the block computes each word from four window taps. On each advance it drops the oldest entry and shifts the new word in at the top. After the last round the block goes idle until the next `init_i`.

Top module: `sha1_wsched`

## Requirements
- R1: While reset is held and after reset is released, before any init, `w_o` reads zero and the block is idle. Reset is `rst_n`, active low.
- R2: In the cycle after `init_i` is sampled high, `w_o` equals bits [511:480] of the block that was sampled with it. This is round 0. The whole block is captured in that single clock.
- R3: For rounds t = 0..15, `w_o` equals block word t, taken from bits [511-32t : 480-32t].
- R4: For rounds t = 16..79, `w_o` equals rotl1(W[t-3] ^ W[t-8] ^ W[t-14] ^ W[t-16]). rotl1 is a left rotate by one bit. The window then drops its oldest word, shifts down and takes that word in at the top.
- R5: Each clock with `next_i` high and `init_i` low moves the schedule forward exactly one round. A clock with both low leaves `w_o` unchanged.
- R6: After the 80th advance, `w_o` reads zero. Further `next_i` pulses change nothing until the next `init_i`.
- R7: When `init_i` and `next_i` are high in the same clock, `init_i` wins. The block loads and the schedule starts at round 0.
- R8: An `init_i` in the middle of a sequence drops it and restarts at round 0 with the new block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load `block_i` and restart at round 0 |
| next_i | input | 1 | Advance one round (engine consumed `w_o`) |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| w_o | output | 32 | Schedule word for the current round |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 16-entry window and 80 rounds. At these values every round, both the load-phase reads and the expansion, is reached in each pass. The round-79 to idle boundary is also reached on every block. Random blocks with random stall gaps exercise the hold behaviour at every point in a sequence. Directed cases cover the all-zero and all-ones blocks, init together with next, and a restart at round 40.

// File: rtl/sha1_wsched_pkg.sv
package sha1_wsched_pkg;
  localparam int NUM_TAPS = 4;
  // Lags behind round t used by the expansion (t-3, t-8, t-14, t-16)
  localparam int TAP_LAG [NUM_TAPS] = '{3, 8, 14, 16};

  function automatic logic [31:0] rotl1_32(input logic [31:0] x);
    return {x[30:0], x[31]};
  endfunction
endpackage

// File: rtl/sha1_wsched_ctr.sv
module sha1_wsched_ctr #(
  parameter int WIN    = 16,
  parameter int ROUNDS = 80,
  localparam int CNT_W = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             next_i,
  output logic [CNT_W-1:0] rnd_o,
  output logic             active_o,
  output logic             loading_o
);
  logic [CNT_W-1:0] rnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rnd_q <= CNT_W'(ROUNDS);
    else if (init_i)              rnd_q <= '0;
    else if (next_i && active_o)  rnd_q <= rnd_q + 1'b1;
  end

  assign active_o  = (rnd_q < CNT_W'(ROUNDS));
  assign loading_o = (rnd_q < CNT_W'(WIN));
  assign rnd_o     = rnd_q;
endmodule

// File: rtl/sha1_wsched_win.sv
module sha1_wsched_win #(
  parameter int WORD_W = 32,
  parameter int WIN    = 16,
  localparam int BLOCK_W = WORD_W * WIN
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       shift_i,
  input  logic [BLOCK_W-1:0]         block_i,
  input  logic [WORD_W-1:0]          new_word_i,
  output logic [WIN-1:0][WORD_W-1:0] win_o
);
  for (genvar i = 0; i < WIN; i++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    logic [WORD_W-1:0] shift_in;
    if (i == WIN - 1) begin : g_top
      assign shift_in = new_word_i;
    end else begin : g_mid
      assign shift_in = win_o[i+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (load_i)  slot_q <= block_i[BLOCK_W-1-i*WORD_W -: WORD_W];
      else if (shift_i) slot_q <= shift_in;
    end
    assign win_o[i] = slot_q;
  end
endmodule

// File: rtl/sha1_wsched_mix.sv
module sha1_wsched_mix
  import sha1_wsched_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [NUM_TAPS-1:0][WORD_W-1:0] taps_i,
  output logic [WORD_W-1:0]               word_o
);
  logic [WORD_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int k = 0; k < NUM_TAPS; k++) acc = acc ^ taps_i[k];
  end
  assign word_o = {acc[WORD_W-2:0], acc[WORD_W-1]};
endmodule

// File: rtl/sha1_wsched.sv
module sha1_wsched
  import sha1_wsched_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WIN    = 16,
  parameter int ROUNDS = 80,
  localparam int BLOCK_W = WORD_W * WIN,
  localparam int CNT_W   = $clog2(ROUNDS + 1),
  localparam int IDX_W   = $clog2(WIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_i,
  input  logic               next_i,
  input  logic [BLOCK_W-1:0] block_i,
  output logic [WORD_W-1:0]  w_o
);
  logic [CNT_W-1:0]                rnd_q;
  logic                            active;
  logic                            loading;
  logic                            shift_en;
  logic [WIN-1:0][WORD_W-1:0]      win_q;
  logic [NUM_TAPS-1:0][WORD_W-1:0] taps;
  logic [WORD_W-1:0]               exp_word;

  sha1_wsched_ctr #(.WIN(WIN), .ROUNDS(ROUNDS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
    .rnd_o(rnd_q), .active_o(active), .loading_o(loading)
  );

  assign shift_en = next_i && !init_i && active && !loading;

  sha1_wsched_win #(.WORD_W(WORD_W), .WIN(WIN)) u_win (
    .clk(clk), .rst_n(rst_n), .load_i(init_i), .shift_i(shift_en),
    .block_i(block_i), .new_word_i(exp_word), .win_o(win_q)
  );

  // Window is oldest-first: slot WIN-lag holds W[t-lag]
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign taps[k] = win_q[WIN - TAP_LAG[k]];
  end

  sha1_wsched_mix #(.WORD_W(WORD_W)) u_mix (.taps_i(taps), .word_o(exp_word));

  always_comb begin
    if (!active)      w_o = '0;
    else if (loading) w_o = win_q[rnd_q[IDX_W-1:0]];
    else              w_o = exp_word;
  end
endmodule

// File: rtl/sha1_wsched_chk.sv
module sha1_wsched_chk #(
  parameter int WORD_W = 32,
  parameter int WIN    = 16,
  parameter int ROUNDS = 80,
  localparam int CNT_W = $clog2(ROUNDS + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       init_i,
  input logic                       next_i,
  input logic [WORD_W-1:0]          top_word,
  input logic [WORD_W-1:0]          w_o,
  input logic [WIN-1:0][WORD_W-1:0] win_q,
  input logic [CNT_W-1:0]           rnd_q
);
  logic adv_exp;
  assign adv_exp = next_i && !init_i && (rnd_q >= CNT_W'(WIN)) && (rnd_q < CNT_W'(ROUNDS));

  AST_INIT_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> w_o == $past(top_word)); // R2
  AST_HOLD_IDLE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !init_i && !next_i |=> $stable(w_o)); // R5
  AST_RND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q <= CNT_W'(ROUNDS)); // R5
  AST_LOAD_PHASE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    next_i && !init_i && rnd_q < CNT_W'(WIN) |=> $stable(win_q)); // R3
  AST_SHIFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_exp |=> win_q[WIN-1] == $past(w_o)); // R4
  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    adv_exp |=> win_q[0] == $past(win_q[1])); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q == CNT_W'(ROUNDS) && !init_i |=> w_o == '0 && $stable(win_q)); // R6
  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    init_i && next_i |=> rnd_q == '0); // R7
endmodule

bind sha1_wsched sha1_wsched_chk #(.WORD_W(WORD_W), .WIN(WIN), .ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
  .top_word(block_i[BLOCK_W-1 -: WORD_W]), .w_o(w_o), .win_q(win_q), .rnd_q(rnd_q)
);

// File: tb/sha1_wsched_tb.sv
module sha1_wsched_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init_i = 1'b0;
  logic         next_i = 1'b0;
  logic [511:0] block_i = '0;
  logic [31:0]  w_o;
  int checks = 0;
  int errors = 0;

  sha1_wsched u_dut (.clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
                     .block_i(block_i), .w_o(w_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_w(input logic [511:0] b, input int t);
    logic [31:0] w [80];
    logic [31:0] x;
    for (int i = 0; i < 16; i++) w[i] = b[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      x = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {x[30:0], x[31]};
    end
    return w[t];
  endfunction

  function automatic logic [511:0] rand_block();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: w_o=%08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_init(input logic [511:0] b);
    block_i = b; init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
  endtask

  task automatic step();
    next_i = 1'b1;
    @(negedge clk);
    next_i = 1'b0;
  endtask

  // Full 80-round pass with random stalls; R3/R4 words, R5 holds, R6 idle
  task automatic run_block(input logic [511:0] b, input int stall_pct);
    do_init(b);
    chk("R2 word0 after init", w_o, b[511:480]);
    for (int t = 0; t < 80; t++) begin
      while (int'($urandom_range(99)) < stall_pct) begin
        @(negedge clk);
        chk("R5 hold on stall", w_o, ref_w(b, t));
      end
      chk(t < 16 ? "R3 load word" : "R4 expanded word", w_o, ref_w(b, t));
      step();
    end
    chk("R6 zero after last round", w_o, 32'h0);
    step();
    chk("R6 next ignored when done", w_o, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [511:0] b1;
    logic [511:0] b2;
    void'($urandom(32'd2024));
    @(negedge clk);
    chk("R1 zero in reset", w_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 zero after reset", w_o, 32'h0);
    step();
    chk("R1 next before init ignored", w_o, 32'h0);

    run_block('0, 0);
    run_block('1, 0);
    run_block({32'h61626380, {14{32'h0}}, 32'h00000018}, 0);
    for (int n = 0; n < 8; n++) run_block(rand_block(), 30);

    // R7: init and next together
    b1 = rand_block();
    block_i = b1; init_i = 1'b1; next_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0; next_i = 1'b0;
    chk("R7 init wins over next", w_o, b1[511:480]);
    step();
    chk("R7 next round after init", w_o, b1[479:448]);

    // R8: restart mid-sequence
    b1 = rand_block();
    b2 = rand_block();
    do_init(b1);
    for (int t = 0; t < 40; t++) step();
    chk("R8 mid-run word40", w_o, ref_w(b1, 40));
    run_block(b2, 10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule